// File: doc/BRIEF.md
# Glitch-Free Per-Bank Clock Output Gate

This block sits between the clock generator of a four-bank, two-outputs-per-bank clock buffer and its output pins. Every output gets its own ungated clock, and the block passes it through or parks it at a fixed level. A global hold request forces outputs to park. A three-level test select can turn that hold into a per-bank control, in which case each bank's own three-level select pair chooses whether that bank keeps running. One bank, the second one, is never parked.

The park level depends on a three-level edge-polarity select. For the fourth bank it also depends on whether that bank's select pair chooses its inverted mode. A hold change never reaches an output straight away. It first passes through a two-flop synchronizer clocked by that output's own clock. The output then switches only at the clock edge that brings the ungated clock onto the park level. As a result an output never shows a runt pulse, either when it stops or when it starts.

Top module: `bank_clk_gate`

## Requirements
- R1: Outputs 2 and 3 (the second bank) always equal their input clocks, whatever the hold, test, edge and select inputs are.
- R2: With `hold_req` low, every output equals its input clock once three rising edges of that output's clock have passed since the last control change.
- R3: With `hold_req` high and `test_sel` not mid (mid is 2'b01), the outputs of banks 1, 3 and 4 sit at their park level and do not toggle.
- R4: With `hold_req` high and `test_sel` mid, each of banks 1, 3 and 4 keeps running unless its 4-bit select field `bank_sel[4b+3:4b]` (bank b counted from 0) is 4'b0000, meaning both digits low. In that case the bank parks.
- R5: The park level of banks 1 and 3, and of bank 4 when it is not inverted, is high when `edge_sel` is low (2'b00) and low when `edge_sel` is mid (2'b01) or high (2'b10 or 2'b11).
- R6: Bank 4 is inverted when both digits of its select field are high, that is, bits 15 and 13 are both 1 (each digit is 2'b1x = high). In that case its park level is low when `edge_sel` is low and high when `edge_sel` is mid or high.
- R7: An output reacts to a control change only after two rising edges of its own clock. With a low park level the switch happens at the following falling edge. With a high park level it happens at the third rising edge. The first high or low phase after the output starts again has full width.
- R8: While `rst_n` is low, every output follows its input clock. Reset clears all synchronizer and gate state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_in | input | 8 | Ungated clocks, two per bank, bank 1 in bits 1:0 |
| hold_req | input | 1 | Global request to park the controllable outputs |
| test_sel | input | 2 | Three-level test select: 00 low, 01 mid, 1x high |
| edge_sel | input | 2 | Three-level edge-polarity select, same encoding |
| bank_sel | input | 16 | Per-bank select pair, 4 bits per bank, bank 1 in bits 3:0 |
| clk_out | output | 8 | Gated clocks |

## Verification
A synchronizer flop that is stuck or left out shows up as an output that parks or restarts one or more own-clock edges too early, or that never does so. The bench can see this at mid-phase samples within the first three edges after a change. A wrong park selection shows as the wrong constant level at the first sample after the park takes effect, in one of the edge and inversion combinations covered by the sweep. A gate flop clocked on the wrong edge leaves the output out of step with its clock for half a period. That gives either a clipped first pulse or a missing transition, which the samples taken just after the switching edge catch.

// File: rtl/bank_clk_gate.sv
`timescale 1ns/1ps
module bank_clk_gate #(
  parameter int NUM_BANKS   = 4,
  parameter int OUTS_PER_BK = 2,
  parameter int FREE_BANK   = 1,
  parameter int INV_BANK    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NOUT = NUM_BANKS * OUTS_PER_BK,
  localparam int SELW = 4 * NUM_BANKS
) (
  input  logic            rst_n,
  input  logic [NOUT-1:0] clk_in,
  input  logic            hold_req,
  input  logic [1:0]      test_sel,
  input  logic [1:0]      edge_sel,
  input  logic [SELW-1:0] bank_sel,
  output logic [NOUT-1:0] clk_out
);

  logic edge_low, test_mid;
  assign edge_low = (edge_sel == 2'b00);
  assign test_mid = (test_sel == 2'b01);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [3:0] sel_b;
    assign sel_b = bank_sel[4*b +: 4];

    if (b == FREE_BANK) begin : g_free
      logic unused_sel;
      assign unused_sel = ^sel_b;
      for (genvar k = 0; k < OUTS_PER_BK; k++) begin : g_out
        assign clk_out[b*OUTS_PER_BK + k] = clk_in[b*OUTS_PER_BK + k];
      end
    end else begin : g_ctl
      logic off_b, park_b, sel_off, sel_inv;
      assign sel_off = (sel_b == 4'b0000);
      assign sel_inv = sel_b[3] & sel_b[1];
      assign off_b   = hold_req & ~(test_mid & ~sel_off);

      if (b == INV_BANK) begin : g_inv
        assign park_b = edge_low ^ sel_inv;
      end else begin : g_std
        logic unused_inv;
        assign unused_inv = sel_inv;
        assign park_b = edge_low;
      end

      for (genvar k = 0; k < OUTS_PER_BK; k++) begin : g_out
        localparam int I = b*OUTS_PER_BK + k;
        logic [SYNC_STAGES-1:0] sync_q;
        logic stop_r, stop_f, stop;

        always_ff @(posedge clk_in[I] or negedge rst_n)
          if (!rst_n) sync_q <= '0;
          else        sync_q <= {sync_q[SYNC_STAGES-2:0], off_b};

        always_ff @(posedge clk_in[I] or negedge rst_n)
          if (!rst_n) stop_r <= 1'b0;
          else        stop_r <= sync_q[SYNC_STAGES-1];

        always_ff @(negedge clk_in[I] or negedge rst_n)
          if (!rst_n) stop_f <= 1'b0;
          else        stop_f <= sync_q[SYNC_STAGES-1];

        assign stop       = park_b ? stop_r : stop_f;
        assign clk_out[I] = stop ? park_b : clk_in[I];
      end
    end
  end

endmodule

// File: rtl/bank_clk_gate_chk.sv
`timescale 1ns/1ps
module bank_clk_gate_chk #(
  parameter int NUM_BANKS   = 4,
  parameter int OUTS_PER_BK = 2,
  parameter int FREE_BANK   = 1,
  parameter int INV_BANK    = 3,
  localparam int NOUT = NUM_BANKS * OUTS_PER_BK,
  localparam int SELW = 4 * NUM_BANKS
) (
  input logic            rst_n,
  input logic [NOUT-1:0] clk_in,
  input logic            hold_req,
  input logic [1:0]      test_sel,
  input logic [1:0]      edge_sel,
  input logic [SELW-1:0] bank_sel,
  input logic [NOUT-1:0] clk_out
);

  for (genvar i = 0; i < NOUT; i++) begin : g_o
    localparam int B = i / OUTS_PER_BK;
    if (B == FREE_BANK) begin : g_free
      AST_FREE_RUN: assert property (@(clk_in[i]) disable iff (!rst_n)
        clk_out[i] == clk_in[i]); // R1
    end else begin : g_ctl
      logic want_off, park;
      logic w_q, p_q;
      logic [1:0] cnt;
      logic [3:0] s;
      assign s = bank_sel[4*B +: 4];
      always_comb begin
        want_off = hold_req;
        if (test_sel == 2'b01 && s != 4'b0000) want_off = 1'b0;
        park = (edge_sel != 2'b00);
        if (!(B == INV_BANK && s[3] && s[1])) park = ~park;
      end

      always_ff @(posedge clk_in[i] or negedge rst_n)
        if (!rst_n) begin
          w_q <= 1'b0; p_q <= 1'b0; cnt <= 2'd0;
        end else begin
          w_q <= want_off;
          p_q <= park;
          if (want_off != w_q || park != p_q) cnt <= 2'd0;
          else if (cnt != 2'd3)                cnt <= cnt + 2'd1;
        end

      AST_PARK_HOLD: assert property (@(clk_in[i]) disable iff (!rst_n)
        (cnt == 2'd3 && w_q && want_off && park == p_q) |-> clk_out[i] == park); // R3
      AST_RUN_FOLLOW: assert property (@(clk_in[i]) disable iff (!rst_n)
        (cnt == 2'd3 && !w_q && !want_off) |-> clk_out[i] == clk_in[i]); // R2
      AST_SYNC_DELAY: assert property (@(posedge clk_in[i]) disable iff (!rst_n)
        (want_off && !w_q && park) |=> !clk_out[i]); // R7
    end
  end

endmodule

bind bank_clk_gate bank_clk_gate_chk #(
  .NUM_BANKS(NUM_BANKS), .OUTS_PER_BK(OUTS_PER_BK),
  .FREE_BANK(FREE_BANK), .INV_BANK(INV_BANK)
) u_chk (
  .rst_n(rst_n), .clk_in(clk_in), .hold_req(hold_req), .test_sel(test_sel),
  .edge_sel(edge_sel), .bank_sel(bank_sel), .clk_out(clk_out)
);

// File: tb/bank_clk_gate_tb.sv
`timescale 1ns/1ps
module bank_clk_gate_tb;
  logic        clk = 1'b0, clk2 = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold_req = 1'b1;
  logic [1:0]  test_sel = 2'b00, edge_sel = 2'b00;
  logic [15:0] bank_sel = 16'h5555;
  logic [7:0]  clk_in, clk_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) clk2 <= ~clk2;
  assign clk_in = {clk2, clk, clk2, clk, clk2, clk, clk2, clk};

  bank_clk_gate u_dut (.rst_n(rst_n), .clk_in(clk_in), .hold_req(hold_req),
    .test_sel(test_sel), .edge_sel(edge_sel), .bank_sel(bank_sel), .clk_out(clk_out));

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic bit m_off(int b);
    if (b == 1 || !hold_req) return 0;
    if (test_sel == 2'b01) return bank_sel[4*b +: 4] == 4'h0;
    return 1;
  endfunction

  function automatic bit m_park(int b);
    bit lo = (edge_sel == 2'b00);
    if (b == 3 && bank_sel[15] && bank_sel[13]) return !lo;
    return lo;
  endfunction

  function automatic string m_tag(int b);
    if (b == 1) return "R1";
    if (!hold_req) return "R2";
    if (m_off(b)) return (b == 3 && bank_sel[15] && bank_sel[13]) ? "R6" : (test_sel == 2'b01 ? "R4" : "R5");
    return "R4";
  endfunction

  task automatic sweep_point();
    logic [7:0] miss = '0, got = '0, want = '0;
    repeat (10) @(posedge clk);
    for (int n = 0; n < 4; n++) begin
      if (n[0]) @(negedge clk); else @(posedge clk);
      #1.25;
      for (int i = 0; i < 8; i++) begin
        logic e;
        e = m_off(i/2) ? m_park(i/2) : clk_in[i];
        if (clk_out[i] !== e && !miss[i]) begin miss[i] = 1; got[i] = clk_out[i]; want[i] = e; end
      end
    end
    for (int i = 0; i < 8; i++)
      chk(miss[i] ? got[i] : 1'b0, miss[i] ? want[i] : 1'b0,
          $sformatf("%s out%0d hold=%b test=%b edge=%b sel=%h", m_tag(i/2), i, hold_req, test_sel, edge_sel, bank_sel));
  endtask

  localparam logic [15:0] SELS [6] = '{16'h0000, 16'hAAAA, 16'hFFFF, 16'h5555, 16'hA050, 16'h0A9A};

  initial begin
    #12.5;
    @(posedge clk); #1.25;
    for (int i = 0; i < 8; i++) chk(clk_out[i], clk_in[i], $sformatf("R8 reset hi out%0d", i));
    @(negedge clk); #1.25;
    for (int i = 0; i < 8; i++) chk(clk_out[i], clk_in[i], $sformatf("R8 reset lo out%0d", i));
    rst_n = 1'b1;

    for (int h = 0; h < 2; h++)
      for (int t = 0; t < 4; t++)
        for (int e = 0; e < 4; e++)
          for (int s = 0; s < 6; s++) begin
            @(negedge clk); #1.25;
            hold_req = h[0]; test_sel = t[1:0]; edge_sel = e[1:0]; bank_sel = SELS[s];
            sweep_point();
          end

    // R7 high park level
    hold_req = 0; test_sel = 2'b00; edge_sel = 2'b00; bank_sel = 16'h5555;
    repeat (8) @(posedge clk);
    @(negedge clk); #1.25; hold_req = 1;
    @(posedge clk); @(posedge clk); @(negedge clk); #1.25;
    chk(clk_out[0], 1'b0, "R7 still running after two edges (park high)");
    @(posedge clk); @(negedge clk); #1.25;
    chk(clk_out[0], 1'b1, "R7 parked high at third edge");
    repeat (4) @(posedge clk);
    @(negedge clk); #1.25; hold_req = 0;
    @(posedge clk); @(posedge clk); @(negedge clk); #1.25;
    chk(clk_out[0], 1'b1, "R7 still parked high after two edges");
    @(posedge clk); #0.3;
    chk(clk_out[0], 1'b1, "R7 first high phase starts at edge");
    #1.9;
    chk(clk_out[0], 1'b1, "R7 first high phase full");
    @(negedge clk); #1.25;
    chk(clk_out[0], 1'b0, "R7 running again (park high)");

    // R7 low park level
    edge_sel = 2'b01;
    repeat (8) @(posedge clk);
    @(posedge clk); #1.25; hold_req = 1;
    @(posedge clk); @(posedge clk); #1.25;
    chk(clk_out[0], 1'b1, "R7 still running after two edges (park low)");
    @(posedge clk); #1.25;
    chk(clk_out[0], 1'b0, "R7 parked low after falling edge");
    repeat (4) @(posedge clk);
    @(posedge clk); #1.25; hold_req = 0;
    @(posedge clk); @(posedge clk); #1.25;
    chk(clk_out[0], 1'b0, "R7 still parked low after two edges");
    @(negedge clk); #0.3;
    chk(clk_out[0], 1'b0, "R7 first low phase starts at falling edge");
    @(posedge clk); #0.3;
    chk(clk_out[0], 1'b1, "R7 first high phase after enable");
    #1.9;
    chk(clk_out[0], 1'b1, "R7 first high phase full (park low)");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #500us;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule